// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact 32-bit processor that completes one instruction per clock. It fetches a word from a private instruction store, splits it into fields, reads two operands from a 32-entry register file, and computes a result in a four-function ALU. A load or store may then access a private word-wide data store, the result is written back, and the program counter is updated, all within that same cycle. It executes register-register add, subtract, AND and OR, immediate add, word load and store, branch on equal and not-equal, and an absolute jump.

Both stores are filled through dedicated write ports, normally while reset is held. After reset is released the core spends one idle cycle arming itself, then starts executing at address 0. A debug port returns any register's contents combinationally. Opcodes or function codes the core does not know are executed as no-ops and latch a flag that stays set until the next reset.

Top module: `sc_core_top`

## Requirements
- R1: There are 32 registers. Register 0 always reads zero and any write to it is dropped. `dbg_data_o` returns the register selected by `dbg_sel_i`.
- R2: With opcode 0 (bits 31:26), the function code (bits 5:0) selects the operation: 32 is add, 34 is subtract (rs−rt), 36 is AND and 37 is OR. The result goes to rd (bits 15:11), with rs in bits 25:21 and rt in bits 20:16.
- R3: Opcode 8 writes rt with rs plus the sign-extended 16-bit immediate (bits 15:0).
- R4: Opcode 35 loads into rt the data word at byte address rs+sext(imm). Address bits 1:0 are ignored, and the word index is address bits 9:2.
- R5: Opcode 43 stores rt into the data word at byte address rs+sext(imm), using the same indexing as R4.
- R6: Opcode 4 (branch if rs equals rt) sets the PC to PC+4+(sext(imm)<<2) when taken, and to PC+4 otherwise. Negative offsets are allowed.
- R7: Opcode 5 (branch if rs differs from rt) uses the same target rule as R6.
- R8: Opcode 2 sets the PC to {PC+4 bits 31:28, instruction bits 25:0, 2'b00}.
- R9: Reset clears the PC to 0. The first clock edge after reset release only arms the core; each later edge executes the instruction at instruction word PC[9:2]. The PC advances by 4 unless a taken branch or a jump redirects it.
- R10: An unknown opcode, or opcode 0 with an unknown function code, writes nothing, advances the PC by 4 and sets `illegal_o`. The flag stays high until reset.
- R11: A write-enable pulse on either load port writes the given word into the instruction or data store at the given word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction store write enable |
| imem_addr_i | input | 8 | Instruction store word index |
| imem_wdata_i | input | 32 | Instruction store write data |
| dmem_we_i | input | 1 | Data store write enable |
| dmem_addr_i | input | 8 | Data store word index |
| dmem_wdata_i | input | 32 | Data store write data |
| dbg_sel_i | input | 5 | Debug register select |
| dbg_data_o | output | 32 | Debug register contents |
| pc_o | output | 32 | Current program counter |
| illegal_o | output | 1 | Sticky illegal-instruction flag |

## Verification
A single instruction can hit a hazard of its own: when a branch compares a register with itself, the PC redirect and the operand read fall in the same cycle, and both sides of the comparison come from the same register read. A store followed directly by a load of the same word exercises the data-store write and read back to back. The bench runs a program where a store at rs−4 is read by the next load, where equal and unequal branches each fall both ways, and where a negative-offset branch spins forever. Results are judged by register contents and the final PC. Values from skipped paths must be absent, and a register named as the destination of an illegal word must stay zero.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;
    logic    use_imm;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
    logic    illegal;
  } ctrl_t;
endpackage

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] rc_i,
  output logic [W-1:0]  ra_o,
  output logic [W-1:0]  rb_o,
  output logic [W-1:0]  rc_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_q[g] = '0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else if (we_i && wa_i == AW'(g)) regs_q[g] <= wd_i;
      end
    end
  end

  assign ra_o = regs_q[ra_i];
  assign rb_o = regs_q[rb_i];
  assign rc_o = regs_q[rc_i];

  p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs_q[$past(wa_i)] == $past(wd_i));
  p_zero_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i == '0) |=> ra_i != '0 || ra_o == '0);
endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         eq_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      default: y_o = a_i | b_i;
    endcase
  end
  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/sc_core_decode.sv
module sc_core_decode
  import sc_core_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o
);
  logic [5:0] op, fn;
  assign op = instr_i[31:26];
  assign fn = instr_i[5:0];

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.dst_rd = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          default: begin
            ctrl_o.rf_we   = 1'b0;
            ctrl_o.illegal = 1'b1;
          end
        endcase
      end
      OP_ADDI: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_LOAD: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_wr  = 1'b1;
      end
      OP_BEQ:  ctrl_o.br_eq = 1'b1;
      OP_BNE:  ctrl_o.br_ne = 1'b1;
      OP_JUMP: ctrl_o.jmp   = 1'b1;
      default: ctrl_o.illegal = 1'b1;
    endcase
  end

  p_ctrl_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.mem_rd, ctrl_o.mem_wr, ctrl_o.br_eq, ctrl_o.br_ne, ctrl_o.jmp, ctrl_o.illegal}));
  p_illegal_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.illegal |-> !ctrl_o.rf_we && !ctrl_o.mem_wr);
endmodule

// File: rtl/sc_core_top.sv
module sc_core_top
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  parameter int IMEM_AW    = $clog2(IMEM_WORDS),
  parameter int DMEM_AW    = $clog2(DMEM_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_addr_i,
  input  logic [31:0]        imem_wdata_i,
  input  logic               dmem_we_i,
  input  logic [DMEM_AW-1:0] dmem_addr_i,
  input  logic [31:0]        dmem_wdata_i,
  input  logic [4:0]         dbg_sel_i,
  output logic [31:0]        dbg_data_o,
  output logic [31:0]        pc_o,
  output logic               illegal_o
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic        run_q, illegal_q;
  logic [31:0] pc_q, pc_d, pc_plus4, instr, imm_sx;
  logic [31:0] rs_val, rt_val, alu_b, alu_y, wb_data, ld_data;
  logic [4:0]  wa;
  logic        eq, taken, rf_we, dm_we;
  ctrl_t       ctrl;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_wdata_i;
  end

  assign instr    = imem[pc_q[IMEM_AW+1:2]];
  assign pc_plus4 = pc_q + 32'd4;
  assign imm_sx   = {{16{instr[15]}}, instr[15:0]};

  sc_core_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .instr_i(instr),
    .ctrl_o (ctrl)
  );

  sc_core_regfile #(.W(XLEN), .NREGS(32)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (instr[25:21]),
    .rb_i  (instr[20:16]),
    .rc_i  (dbg_sel_i),
    .ra_o  (rs_val),
    .rb_o  (rt_val),
    .rc_o  (dbg_data_o),
    .we_i  (rf_we),
    .wa_i  (wa),
    .wd_i  (wb_data)
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

  sc_core_alu #(.W(XLEN)) u_alu (
    .op_i(ctrl.alu_op),
    .a_i (rs_val),
    .b_i (alu_b),
    .y_o (alu_y),
    .eq_o(eq)
  );

  // data store: load port has priority over core stores
  assign ld_data = dmem[alu_y[DMEM_AW+1:2]];
  assign dm_we   = run_q && ctrl.mem_wr;
  always_ff @(posedge clk_i) begin
    if (dmem_we_i)  dmem[dmem_addr_i] <= dmem_wdata_i;
    else if (dm_we) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
  end

  assign wa      = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctrl.mem_rd ? ld_data : alu_y;
  assign rf_we   = run_q && ctrl.rf_we;

  assign taken = (ctrl.br_eq && eq) || (ctrl.br_ne && !eq);

  always_comb begin
    if (ctrl.jmp)  pc_d = {pc_plus4[31:28], instr[25:0], 2'b00};
    else if (taken) pc_d = pc_plus4 + {imm_sx[29:0], 2'b00};
    else           pc_d = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      pc_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        pc_q <= pc_d;
        if (ctrl.illegal) illegal_q <= 1'b1;
      end
    end
  end

  assign pc_o      = pc_q;
  assign illegal_o = illegal_q;

  p_pc_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);
  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !ctrl.jmp && !ctrl.br_eq && !ctrl.br_ne) |=> pc_q == $past(pc_q) + 32'd4);
  p_illegal_skip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && ctrl.illegal) |=> illegal_o && pc_q == $past(pc_q) + 32'd4);
  p_illegal_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);
  p_jump_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && ctrl.jmp) |=> pc_q[27:2] == $past(instr[25:0]));
endmodule

// File: tb/tb_sc_core_top.sv
module tb_sc_core_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0, dmem_we = 1'b0;
  logic [7:0]  imem_addr = '0, dmem_addr = '0;
  logic [31:0] imem_wdata = '0, dmem_wdata = '0;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_data, pc;
  logic        illegal;

  int n_chk = 0, n_bad = 0;
  bit run_done = 1'b0, mon_done = 1'b0;

  always #10 clk = ~clk;

  sc_core_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_we_i(imem_we), .imem_addr_i(imem_addr), .imem_wdata_i(imem_wdata),
    .dmem_we_i(dmem_we), .dmem_addr_i(dmem_addr), .dmem_wdata_i(dmem_wdata),
    .dbg_sel_i(dbg_sel), .dbg_data_o(dbg_data), .pc_o(pc), .illegal_o(illegal)
  );

  typedef struct { logic [4:0] idx; logic [31:0] val; string req; } exp_t;
  exp_t sb_q[$];

  function automatic logic [31:0] r_ins(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] j_ins(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(logic [4:0] idx, logic [31:0] val, string req);
    exp_t e;
    e.idx = idx; e.val = val; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic load_word(bit is_imem, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    if (is_imem) begin imem_we = 1'b1; imem_addr = a; imem_wdata = d; end
    else         begin dmem_we = 1'b1; dmem_addr = a; dmem_wdata = d; end
    @(negedge clk);
    imem_we = 1'b0; dmem_we = 1'b0;
  endtask

  // monitor: pops expectations and reads registers through the debug port
  initial begin
    wait (run_done);
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      dbg_sel = e.idx;
      #1;
      check(e.req, dbg_data, e.val);
    end
    mon_done = 1'b1;
  end

  // driver
  initial begin
    logic [31:0] prog [24];
    for (int i = 0; i < 24; i++) prog[i] = 32'd0;
    prog[0]  = i_ins(6'd8, 5'd0, 5'd1, 16'd20);          // r1 = 20
    prog[1]  = i_ins(6'd8, 5'd0, 5'd2, 16'hFFFA);        // r2 = -6
    prog[2]  = r_ins(6'd32, 5'd1, 5'd2, 5'd3);
    prog[3]  = r_ins(6'd34, 5'd1, 5'd2, 5'd4);
    prog[4]  = r_ins(6'd36, 5'd1, 5'd2, 5'd5);
    prog[5]  = r_ins(6'd37, 5'd1, 5'd2, 5'd6);
    prog[6]  = i_ins(6'd8, 5'd1, 5'd0, 16'd5);           // write to r0
    prog[7]  = i_ins(6'd35, 5'd1, 5'd7, 16'd2);          // addr 22 -> word 5
    prog[8]  = i_ins(6'd35, 5'd1, 5'd8, 16'd4);          // addr 24 -> word 6
    prog[9]  = i_ins(6'd43, 5'd1, 5'd4, 16'hFFFC);       // word 4 = r4
    prog[10] = i_ins(6'd35, 5'd0, 5'd9, 16'd16);
    prog[11] = i_ins(6'd4, 5'd1, 5'd1, 16'd1);           // taken
    prog[12] = i_ins(6'd8, 5'd0, 5'd10, 16'd99);
    prog[13] = i_ins(6'd4, 5'd1, 5'd2, 16'd1);           // not taken
    prog[14] = i_ins(6'd8, 5'd0, 5'd11, 16'd7);
    prog[15] = i_ins(6'd5, 5'd1, 5'd2, 16'd1);           // taken
    prog[16] = i_ins(6'd8, 5'd0, 5'd12, 16'd99);
    prog[17] = i_ins(6'd5, 5'd1, 5'd1, 16'd1);           // not taken
    prog[18] = i_ins(6'd8, 5'd0, 5'd13, 16'd9);
    prog[19] = i_ins(6'd63, 5'd1, 5'd14, 16'd5);         // bad opcode
    prog[20] = r_ins(6'd6, 5'd1, 5'd1, 5'd15);           // bad funct
    prog[21] = j_ins(26'd23);
    prog[22] = i_ins(6'd8, 5'd0, 5'd16, 16'd99);
    prog[23] = i_ins(6'd4, 5'd0, 5'd0, 16'hFFFF);        // spin

    // R11: load both stores while reset is held
    for (int i = 0; i < 24; i++) load_word(1'b1, 8'(i), prog[i]);
    load_word(1'b0, 8'd5, 32'h1234_5678);
    load_word(1'b0, 8'd6, 32'hFFFF_FFF0);

    @(negedge clk);
    check("R9 reset pc", pc, 32'd0);
    check("R10 reset flag", {31'd0, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 arming cycle pc", pc, 32'd0);
    @(negedge clk);
    check("R9 first step pc", pc, 32'd4);
    @(negedge clk);
    check("R9 second step pc", pc, 32'd8);
    repeat (3) @(negedge clk);
    check("R10 flag clear before bad word", {31'd0, illegal}, 32'd0);
    repeat (40) @(negedge clk);
    check("R8 R6 final spin pc", pc, 32'd92);
    check("R10 flag set", {31'd0, illegal}, 32'd1);
    repeat (3) @(negedge clk);
    check("R10 flag sticky", {31'd0, illegal}, 32'd1);

    push_exp(5'd1, 32'd20, "R3 addi positive");
    push_exp(5'd2, 32'hFFFF_FFFA, "R3 addi sign-extended");
    push_exp(5'd3, 32'd14, "R2 add");
    push_exp(5'd4, 32'd26, "R2 sub");
    push_exp(5'd5, 32'd16, "R2 and");
    push_exp(5'd6, 32'hFFFF_FFFE, "R2 or");
    push_exp(5'd0, 32'd0, "R1 r0 stays zero");
    push_exp(5'd7, 32'h1234_5678, "R4 load low bits ignored");
    push_exp(5'd8, 32'hFFFF_FFF0, "R4 load aligned");
    push_exp(5'd9, 32'd26, "R5 store then load");
    push_exp(5'd10, 32'd0, "R6 beq taken skips");
    push_exp(5'd11, 32'd7, "R6 beq not taken falls through");
    push_exp(5'd12, 32'd0, "R7 bne taken skips");
    push_exp(5'd13, 32'd9, "R7 bne not taken falls through");
    push_exp(5'd14, 32'd0, "R10 bad opcode no write");
    push_exp(5'd15, 32'd0, "R10 bad funct no write");
    push_exp(5'd16, 32'd0, "R8 jump skips");
    run_done = 1'b1;
  end

  // watchdog and summary
  initial begin
    int cyc;
    cyc = 0;
    while (!mon_done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!mon_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule